// File: doc/BRIEF.md
# Cascadable Serial Configuration Store

This block is the storage side of a master-serial FPGA configuration path. It keeps a bitstream as a one-bit-wide array and, once enabled, presents one bit on its data line after each rising edge of the configuration clock. An internal bit counter moves through the array from index zero upward. When the array has been fully sent, the block stops driving its data line and pulls its chain-enable output low. That output feeds the chip-enable input of the next store, so several stores deliver one long bitstream in a fixed order.

The reset/output-enable input can be set to either active level by a polarity select input. While reset is in force, the output is released and the counter returns to zero. A high chip-enable input puts the block in standby: the counter holds and the output is released. Pulling the serial-enable pin low selects programming mode. In that mode the output is off and the array is loaded one byte at a time through a strobe, an address and a data input. A write-protect input blocks every write.

The data line is brought out as a value plus an active-high drive enable, and the pad buffer sits outside the block.

Top module: `cfg_serial_store`

## Requirements
- R1: While reset is in force, `dout_oe` is 0 and `ceo_n` is 1. The next pass after reset starts at bit index 0.
- R2: With `rst_pol` = 1 a high `rst_oe` is reset and a low one is normal operation. With `rst_pol` = 0 a low `rst_oe` is reset and a high one is normal operation.
- R3: With reset released, `ce_n` = 0 and `ser_en_n` = 1, each rising clock edge drives the next bit on `dout` with `dout_oe` = 1, starting at index 0 on the first edge. Bit index 8*a+j is bit (7-j) of byte address a, so each byte goes out MSB first.
- R4: When `ce_n` = 1, `dout_oe` drops at once and the counter holds. When `ce_n` returns to 0, the stream resumes at the bit after the last one driven, with none lost or repeated.
- R5: On the rising edge after the last bit (index DEPTH-1), `dout_oe` goes to 0 and `ceo_n` goes to 0. Both stay there while `ce_n` = 0 and neither reset nor programming mode is applied.
- R6: `ceo_n` is 1 whenever `ce_n` is 1, reset is in force, or `ser_en_n` is 0.
- R7: While `ser_en_n` = 0, `dout_oe` is 0 and the counter is held at 0. A high `prog_we` at a rising edge writes `prog_data` into byte `prog_addr`.
- R8: While `wp` = 1, a `prog_we` strobe leaves the array unchanged.
- R9: `dout_oe` = 1 and `ceo_n` = 0 never occur together. In a chain of two stores, where the first store's `ceo_n` drives the second store's `ce_n`, the combined stream is the first image followed by the second, and the two `dout_oe` outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; the data line advances on its rising edge |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| rst_oe | input | 1 | Reset / output enable; its active level is set by `rst_pol` |
| rst_pol | input | 1 | 1: high `rst_oe` is reset; 0: low `rst_oe` is reset |
| ser_en_n | input | 1 | Low selects programming mode |
| wp | input | 1 | Write protect, active high |
| prog_we | input | 1 | Byte write strobe, sampled on the rising clock edge |
| prog_addr | input | $clog2(DEPTH/8) | Byte address of the write |
| prog_data | input | 8 | Byte written; its bit 7 is streamed first |
| dout | output | 1 | Serial bit value |
| dout_oe | output | 1 | Drive enable for the external data pad buffer |
| ceo_n | output | 1 | Chain enable output, active low, to the next store's `ce_n` |

## Verification
On every cycle, the embedded properties check four things: the counter steps by one while the block is active, it holds in standby, it sits at zero in programming mode, and the chain hand-off stays asserted once it is reached. They also check that driving the data line and asserting the hand-off never overlap. The bench scenarios are needed for the rest: the actual bit values and their MSB-first order across a two-store chain, the one-cycle gap at the hand-off, the loss-free resume after standby, both reset polarities, and a protected write that must leave the streamed image unchanged.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

   localparam int unsigned BYTE_W = 8;

   // Resolve the reset/output-enable pin against its polarity select.
   function automatic logic rst_is_active(input logic pol_high, input logic lvl);
      return pol_high ? lvl : ~lvl;
   endfunction

   typedef struct packed {
      logic              we;
      logic [BYTE_W-1:0] data;
   } wr_req_t;

endpackage

// File: rtl/cfg_store_prog.sv
module cfg_store_prog
   import cfg_store_pkg::*;
#(
   parameter int unsigned AW = 7
) (
   input  logic              ser_en_n,
   input  logic              wp,
   input  logic              prog_we,
   input  logic [AW-1:0]     prog_addr,
   input  logic [BYTE_W-1:0] prog_data,
   output wr_req_t           req,
   output logic [AW-1:0]     req_addr
);

   // A write reaches the array only in programming mode and without protection.
   always_comb begin
      req.we   = prog_we & ~ser_en_n & ~wp;
      req.data = prog_data;
      req_addr = prog_addr;
   end

endmodule

// File: rtl/cfg_store_array.sv
module cfg_store_array
   import cfg_store_pkg::*;
#(
   parameter int unsigned BYTES = 128,
   localparam int unsigned AW   = $clog2(BYTES)
) (
   input  logic          clk,
   input  wr_req_t       req,
   input  logic [AW-1:0] wr_addr,
   input  logic [AW-1:0] rd_byte,
   input  logic [2:0]    rd_bit,
   output logic          rd_val
);

   logic [BYTE_W-1:0] mem [BYTES];

   always_ff @(posedge clk) begin
      if (req.we) mem[wr_addr] <= req.data;
   end

   // Bit position 0 inside a byte maps to its MSB.
   always_comb rd_val = mem[rd_byte][3'd7 - rd_bit];

endmodule

// File: rtl/cfg_store_seq.sv
module cfg_store_seq #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_act,
   input  logic          ce_n,
   input  logic          ser_en_n,
   input  logic          bit_val,
   output logic [CW-1:0] bit_idx,
   output logic          dout,
   output logic          dout_oe,
   output logic          ceo_n
);

   localparam logic [CW-1:0] END_IDX = CW'(DEPTH);

   logic [CW-1:0] cnt;
   logic          oe_q;
   logic          ceo_q;
   logic          dq;
   logic          hold_zero;
   logic          at_end;

   always_comb begin
      hold_zero = rst_act | ~ser_en_n;
      at_end    = (cnt == END_IDX);
      bit_idx   = cnt;
   end

   always_ff @(posedge clk) begin
      if (hold_zero) begin
         cnt   <= '0;
         oe_q  <= 1'b0;
         ceo_q <= 1'b1;
         dq    <= 1'b0;
      end else if (ce_n) begin
         oe_q  <= 1'b0;
         ceo_q <= 1'b1;
      end else if (!at_end) begin
         dq    <= bit_val;
         cnt   <= cnt + 1'b1;
         oe_q  <= 1'b1;
      end else begin
         oe_q  <= 1'b0;
         ceo_q <= 1'b0;
      end
   end

   // Enables are gated straight from the pins so release is immediate.
   always_comb begin
      dout    = dq;
      dout_oe = oe_q & ~ce_n & ~hold_zero;
      ceo_n   = ceo_q | ce_n | hold_zero;
   end

   // R3: an active, unfinished store moves exactly one bit per edge
   a_r3_advance: assert property (@(posedge clk) disable iff (rst_act)
      (!ce_n && ser_en_n && !at_end) |=> (cnt == $past(cnt) + 1'b1));

   // R4: standby freezes the counter
   a_r4_standby_hold: assert property (@(posedge clk) disable iff (rst_act)
      (ce_n && ser_en_n) |=> $stable(cnt));

   // R5: the hand-off stays asserted while still selected
   a_r5_ceo_sticky: assert property (@(posedge clk) disable iff (rst_act)
      (!ceo_q && !ce_n && ser_en_n) |=> !ceo_q);

   // R7: programming mode parks the counter at zero
   a_r7_prog_zero: assert property (@(posedge clk) disable iff (rst_act)
      !ser_en_n |=> (cnt == '0));

   // R9: never drive data while handing off
   a_r9_exclusive: assert property (@(posedge clk) disable iff (rst_act)
      !(dout_oe && !ceo_n));

endmodule

// File: rtl/cfg_serial_store.sv
module cfg_serial_store
   import cfg_store_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned BYTES = DEPTH / BYTE_W,
   localparam int unsigned AW    = $clog2(BYTES),
   localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          ce_n,
   input  logic          rst_oe,
   input  logic          rst_pol,
   input  logic          ser_en_n,
   input  logic          wp,
   input  logic          prog_we,
   input  logic [AW-1:0] prog_addr,
   input  logic [7:0]    prog_data,
   output logic          dout,
   output logic          dout_oe,
   output logic          ceo_n
);

   generate
      if (DEPTH < 16) begin : g_chk_min
         $error("DEPTH must be at least 16 bits");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_chk_pow2
         $error("DEPTH must be a power of two");
      end
   endgenerate

   logic          rst_act;
   wr_req_t       req;
   logic [AW-1:0] req_addr;
   logic [CW-1:0] bit_idx;
   logic          bit_val;

   always_comb rst_act = rst_is_active(rst_pol, rst_oe);

   cfg_store_prog #(.AW(AW)) u_prog (
      .ser_en_n  (ser_en_n),
      .wp        (wp),
      .prog_we   (prog_we),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .req       (req),
      .req_addr  (req_addr)
   );

   cfg_store_array #(.BYTES(BYTES)) u_array (
      .clk     (clk),
      .req     (req),
      .wr_addr (req_addr),
      .rd_byte (bit_idx[AW+2:3]),
      .rd_bit  (bit_idx[2:0]),
      .rd_val  (bit_val)
   );

   cfg_store_seq #(.DEPTH(DEPTH)) u_seq (
      .clk      (clk),
      .rst_act  (rst_act),
      .ce_n     (ce_n),
      .ser_en_n (ser_en_n),
      .bit_val  (bit_val),
      .bit_idx  (bit_idx),
      .dout     (dout),
      .dout_oe  (dout_oe),
      .ceo_n    (ceo_n)
   );

   // R1: reset in force keeps the data pad released
   always_comb begin
      if (rst_act) a_r1_reset_quiet: assert (!dout_oe);
   end

endmodule

// File: tb/cfg_serial_store_tb.sv
module cfg_serial_store_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 32;
   localparam int BYTES      = DEPTH / 8;
   localparam int AW         = $clog2(BYTES);

   logic          clk = 1'b0;
   logic          ce_n_a = 1'b1;
   logic          rst_oe = 1'b1;
   logic          rst_pol = 1'b1;
   logic          ser_en_n = 1'b1;
   logic          wp = 1'b0;
   logic          we_a = 1'b0;
   logic          we_b = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic          dout_a, oe_a, ceo_a;
   logic          dout_b, oe_b, ceo_b;

   int total = 0;
   int bad   = 0;
   logic mon_on = 1'b0;
   bit   exp_q [$];
   logic [7:0] img_a [BYTES];
   logic [7:0] img_b [BYTES];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_serial_store #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .ce_n(ce_n_a), .rst_oe(rst_oe), .rst_pol(rst_pol),
      .ser_en_n(ser_en_n), .wp(wp), .prog_we(we_a), .prog_addr(addr),
      .prog_data(wdata), .dout(dout_a), .dout_oe(oe_a), .ceo_n(ceo_a));

   cfg_serial_store #(.DEPTH(DEPTH)) u_dut_b (
      .clk(clk), .ce_n(ceo_a), .rst_oe(rst_oe), .rst_pol(rst_pol),
      .ser_en_n(ser_en_n), .wp(wp), .prog_we(we_b), .prog_addr(addr),
      .prog_data(wdata), .dout(dout_b), .dout_oe(oe_b), .ceo_n(ceo_b));

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   function automatic bit img_bit(input logic [7:0] img [BYTES], input int idx);
      return img[idx / 8][7 - (idx % 8)];
   endfunction

   task automatic push_image(input bit sel_b, input int count);
      for (int i = 0; i < count; i++)
         exp_q.push_back(sel_b ? img_bit(img_b, i) : img_bit(img_a, i));
   endtask

   // Scoreboard monitor: pops one expected bit per driven cycle (R3, R9)
   always @(negedge clk) begin
      if (mon_on && (oe_a || oe_b)) begin
         total++;
         if (oe_a && oe_b) begin
            bad++;
            $display("FAIL R9: actual=both driving expected=one driver");
         end else if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R3: actual=unexpected bit expected=no output");
         end else begin
            bit e;
            logic v;
            e = exp_q.pop_front();
            v = oe_a ? dout_a : dout_b;
            if (v !== e) begin
               bad++;
               $display("FAIL R3: actual=%0b expected=%0b", v, e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < BYTES; i++) begin
         img_a[i] = 8'hA5 ^ 8'(i * 37);
         img_b[i] = 8'h3C + 8'(i * 19);
      end

      // R1: high-active reset asserted
      tick(3);
      check("R1 oe", oe_a, 1'b0);
      check("R1 ceo", ceo_a, 1'b1);
      check("R6 b ceo", ceo_b, 1'b1);

      // R7: programming mode with reset released
      rst_oe = 1'b0;
      ser_en_n = 1'b0;
      ce_n_a = 1'b0;
      tick(1);
      check("R7 oe in prog", oe_a, 1'b0);
      check("R6 ceo in prog", ceo_a, 1'b1);
      for (int i = 0; i < BYTES; i++) begin
         addr = AW'(i); wdata = img_a[i]; we_a = 1'b1; tick(1); we_a = 1'b0;
         wdata = img_b[i]; we_b = 1'b1; tick(1); we_b = 1'b0;
      end
      // R8: protected write must not change byte 1 of image A
      wp = 1'b1;
      addr = AW'(1); wdata = ~img_a[1]; we_a = 1'b1; tick(1); we_a = 1'b0;
      wp = 1'b0;
      check("R7 oe after writes", oe_a, 1'b0);

      // R3/R5/R9: full two-store chain pass (byte 1 streamed covers R8)
      push_image(1'b0, DEPTH);
      push_image(1'b1, DEPTH);
      mon_on = 1'b1;
      ser_en_n = 1'b1;
      tick(2 * DEPTH + 6);
      check("R9 queue drained", exp_q.size() == 0, 1'b1);
      check("R5 a ceo low", ceo_a, 1'b0);
      check("R5 a oe off", oe_a, 1'b0);
      check("R5 b ceo low", ceo_b, 1'b0);
      check("R5 b oe off", oe_b, 1'b0);

      // R6: deselect releases the chain at once
      ce_n_a = 1'b1;
      #1;
      check("R6 a ceo", ceo_a, 1'b1);
      check("R6 b ceo", ceo_b, 1'b1);
      check("R6 b oe", oe_b, 1'b0);

      // R2: low-active reset asserted while selected
      rst_pol = 1'b0;
      rst_oe = 1'b0;
      ce_n_a = 1'b0;
      tick(2);
      check("R2 low reset oe", oe_a, 1'b0);
      check("R2 low reset ceo", ceo_a, 1'b1);

      // R2/R4: release, stream 6 bits, standby, resume 6 bits
      push_image(1'b0, 12);
      rst_oe = 1'b1;
      tick(6);
      check("R4 six consumed", exp_q.size() == 6, 1'b1);
      ce_n_a = 1'b1;
      #1;
      check("R4 oe drops", oe_a, 1'b0);
      tick(3);
      check("R4 oe in standby", oe_a, 1'b0);
      check("R4 none consumed", exp_q.size() == 6, 1'b1);
      ce_n_a = 1'b0;
      tick(6);
      check("R4 resumed", exp_q.size() == 0, 1'b1);

      // R1: reset mid-stream restarts at bit 0
      rst_oe = 1'b0;
      tick(2);
      check("R1 oe mid reset", oe_a, 1'b0);
      push_image(1'b0, 4);
      rst_oe = 1'b1;
      tick(4);
      check("R1 restart at zero", exp_q.size() == 0, 1'b1);
      mon_on = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule